// File: doc/BRIEF.md
# Firmware Image Admission Gate

This block decides whether a firmware image arriving at the device may replace the running image. It keeps two logical entry points: a primary download port, which every download must pass, and a downgrade port, which must additionally be open when the image would lower the firmware version. Each port carries a locked bit and a relock-on-power-cycle flag. Only a requester already proven to be the device owner can change these attributes; the gate receives that proof as a single input and performs no authentication of its own.

When a download request arrives, the gate compares the image version with a stored minimum-version floor and checks the ports that the request needs. A refused request is answered at once, before any image data is taken. An admitted request waits for a pass or fail verdict from an external signature verifier. The gate then either commits the image or discards it, and reports a status code. A commit that is not a downgrade raises the floor to the new version. A power-cycle event returns every port whose relock flag is set to the locked state and abandons any download in progress.

The controller has three states. IDLE waits for a request. WAIT_SIG holds an admitted image while it waits for the verifier. REPORT presents the outcome for one cycle. The transitions are:
- IDLE to REPORT when a request is refused.
- IDLE to WAIT_SIG when a request is admitted.
- WAIT_SIG to REPORT when the verdict arrives.
- REPORT back to IDLE unconditionally.
- Any state to IDLE on a power-cycle event.

Top module: `fwdl_gate`

## Requirements
- R1: After `rst_n` is released, both ports are locked and both relock flags are set (`port_locked` = 2'b11, `port_lock_on_por` = 2'b11). The floor is 0, and `dl_busy`, `dl_done`, `dl_commit` and `attr_resp_valid` are all low.
- R2: When a request is sampled in IDLE while the primary port (index 0) is locked, `dl_done` is high in the next cycle with status 1 (primary locked), `dl_commit` is low, and `dl_busy` never rises.
- R3: When the primary port is open, a request whose version is strictly below the floor while the downgrade port (index 1) is locked is answered in the next cycle with status 2 (downgrade locked), and no image is taken.
- R4: A request whose version is below the floor is admitted when both ports are open. If its signature passes, it commits and the floor is left unchanged.
- R5: An admitted request holds `dl_busy` high until `sig_valid` is sampled. In the next cycle, a pass gives `dl_done` with status 0 (success) and `dl_commit` high for one cycle.
- R6: A failed signature gives `dl_done` with status 3 (signature failure) and `dl_discard` high, with no commit. The floor does not change.
- R7: A successful commit that is not a downgrade sets the floor to the image version from the cycle after `dl_done`. The floor never decreases. A version equal to the floor is not a downgrade.
- R8: An attribute write with `attr_wr_owner` high changes the selected port's locked bit and relock flag (selector 0 is the primary port, 1 is the downgrade port). The new values are visible in the next cycle, together with `attr_resp_valid` and code 0.
- R9: An attribute write with `attr_wr_owner` low leaves both ports unchanged and is answered in the next cycle with code 4 (access denied).
- R10: When `por` is sampled high, each port whose relock flag is set becomes locked, and each port whose flag is clear keeps its locked bit. A pending download is dropped without `dl_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low initialisation of all state, including the attribute store |
| por | input | 1 | Synchronous power-cycle event |
| attr_wr_valid | input | 1 | Attribute write strobe |
| attr_wr_sel | input | 1 | Port selector: 0 is the primary port, 1 is the downgrade port |
| attr_wr_owner | input | 1 | Writer has been authenticated as the owner |
| attr_wr_locked | input | 1 | New locked bit |
| attr_wr_lock_on_por | input | 1 | New relock-on-power-cycle flag |
| attr_resp_valid | output | 1 | Attribute write answered |
| attr_resp_code | output | 3 | 0 accepted, 4 access denied |
| port_locked | output | 2 | Locked bit per port |
| port_lock_on_por | output | 2 | Relock flag per port |
| dl_req_valid | input | 1 | Download request strobe |
| dl_req_version | input | VER_W | Version of the offered image |
| sig_valid | input | 1 | Verifier verdict strobe |
| sig_pass | input | 1 | Verdict: 1 means the signature is good |
| dl_busy | output | 1 | Image admitted; waiting for the verdict |
| dl_done | output | 1 | Outcome valid for one cycle |
| dl_status | output | 3 | 0 ok, 1 primary locked, 2 downgrade locked, 3 signature failure |
| dl_commit | output | 1 | Install the new image |
| dl_discard | output | 1 | Drop the new image; the running image stays |
| rollback_floor | output | VER_W | Minimum version that does not count as a downgrade |

## Verification
On every cycle, the assertions check five properties:
- A request in IDLE against a locked primary port is refused in the next cycle.
- A failed verdict always leads to a discard.
- A power-cycle event relocks each flagged port.
- A non-owner write changes no port and is answered with a denial.
- The floor never moves downwards.

Some properties depend on a history of configuration and version values, so only the bench scenarios can show them. These are the ordering between the two refusal codes, the admission of a downgrade once both ports are open, a floor raised only by non-downgrade commits, the equal-version boundary, and a download dropped by a power-cycle event in mid-flight.

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;

    localparam int NUM_PORTS = 2;
    localparam int SEL_W     = 1;
    localparam int PRIMARY   = 0;
    localparam int DOWNGRADE = 1;

    typedef enum logic [2:0] {
        ST_OK          = 3'd0,
        ST_PRIM_LOCKED = 3'd1,
        ST_DOWN_LOCKED = 3'd2,
        ST_SIG_FAIL    = 3'd3,
        ST_DENIED      = 3'd4
    } status_e;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_WAIT_SIG = 2'd1,
        S_REPORT   = 2'd2
    } state_e;

endpackage

// File: rtl/fwdl_port_cell.sv
module fwdl_port_cell #(
    parameter logic DEF_LOCKED = 1'b1,
    parameter logic DEF_LOR    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por,
    input  logic wr_en,
    input  logic wr_locked,
    input  logic wr_lor,
    output logic locked,
    output logic lock_on_por
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked      <= DEF_LOCKED;
            lock_on_por <= DEF_LOR;
        end else if (por) begin
            if (lock_on_por) begin
                locked <= 1'b1;
            end
        end else if (wr_en) begin
            locked      <= wr_locked;
            lock_on_por <= wr_lor;
        end
    end

endmodule

// File: rtl/fwdl_floor_reg.sv
module fwdl_floor_reg #(
    parameter int VER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [VER_W-1:0] upd_val,
    input  logic [VER_W-1:0] probe_ver,
    output logic             probe_below,
    output logic [VER_W-1:0] floor_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            floor_q <= '0;
        end else if (upd_en && (upd_val > floor_q)) begin
            floor_q <= upd_val;
        end
    end

    assign probe_below = (probe_ver < floor_q);

endmodule

// File: rtl/fwdl_gate.sv
module fwdl_gate
    import fwdl_pkg::*;
#(
    parameter int                   VER_W       = 8,
    parameter logic [NUM_PORTS-1:0] DEF_LOCKED  = '1,
    parameter logic [NUM_PORTS-1:0] DEF_LOR     = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 por,
    input  logic                 attr_wr_valid,
    input  logic                 attr_wr_sel,
    input  logic                 attr_wr_owner,
    input  logic                 attr_wr_locked,
    input  logic                 attr_wr_lock_on_por,
    output logic                 attr_resp_valid,
    output logic [2:0]           attr_resp_code,
    output logic [1:0]           port_locked,
    output logic [1:0]           port_lock_on_por,
    input  logic                 dl_req_valid,
    input  logic [VER_W-1:0]     dl_req_version,
    input  logic                 sig_valid,
    input  logic                 sig_pass,
    output logic                 dl_busy,
    output logic                 dl_done,
    output logic [2:0]           dl_status,
    output logic                 dl_commit,
    output logic                 dl_discard,
    output logic [VER_W-1:0]     rollback_floor
);

    state_e          state_q, state_d;
    status_e         status_q, status_d;
    logic [VER_W-1:0] ver_q;
    logic            down_q;
    logic            req_below;
    logic            floor_upd;
    status_e         resp_code_q;

    // attribute store, one cell per port
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        logic wr_en_i;
        assign wr_en_i = attr_wr_valid && attr_wr_owner && (attr_wr_sel == SEL_W'(i));
        fwdl_port_cell #(
            .DEF_LOCKED (DEF_LOCKED[i]),
            .DEF_LOR    (DEF_LOR[i])
        ) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .por         (por),
            .wr_en       (wr_en_i),
            .wr_locked   (attr_wr_locked),
            .wr_lor      (attr_wr_lock_on_por),
            .locked      (port_locked[i]),
            .lock_on_por (port_lock_on_por[i])
        );
    end

    fwdl_floor_reg #(.VER_W(VER_W)) u_floor (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_en      (floor_upd),
        .upd_val     (ver_q),
        .probe_ver   (dl_req_version),
        .probe_below (req_below),
        .floor_q     (rollback_floor)
    );

    // next-state decision
    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        unique case (state_q)
            S_IDLE: begin
                if (dl_req_valid) begin
                    if (port_locked[PRIMARY]) begin
                        state_d  = S_REPORT;
                        status_d = ST_PRIM_LOCKED;
                    end else if (req_below && port_locked[DOWNGRADE]) begin
                        state_d  = S_REPORT;
                        status_d = ST_DOWN_LOCKED;
                    end else begin
                        state_d  = S_WAIT_SIG;
                        status_d = ST_OK;
                    end
                end
            end
            S_WAIT_SIG: begin
                if (sig_valid) begin
                    state_d  = S_REPORT;
                    status_d = sig_pass ? ST_OK : ST_SIG_FAIL;
                end
            end
            S_REPORT: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            status_q <= ST_OK;
        end else if (por) begin
            state_q  <= S_IDLE;
            status_q <= ST_OK;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
        end
    end

    // captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ver_q  <= '0;
            down_q <= 1'b0;
        end else if (state_q == S_IDLE && dl_req_valid) begin
            ver_q  <= dl_req_version;
            down_q <= req_below;
        end
    end

    // attribute write response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            attr_resp_valid <= 1'b0;
            resp_code_q     <= ST_OK;
        end else if (por) begin
            attr_resp_valid <= 1'b0;
            resp_code_q     <= ST_OK;
        end else begin
            attr_resp_valid <= attr_wr_valid;
            resp_code_q     <= attr_wr_owner ? ST_OK : ST_DENIED;
        end
    end
    assign attr_resp_code = resp_code_q;

    // outputs
    always_comb begin
        dl_busy    = 1'b0;
        dl_done    = 1'b0;
        dl_status  = ST_OK;
        dl_commit  = 1'b0;
        dl_discard = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_WAIT_SIG: dl_busy = 1'b1;
            S_REPORT: begin
                dl_done    = 1'b1;
                dl_status  = status_q;
                dl_commit  = (status_q == ST_OK);
                dl_discard = (status_q == ST_SIG_FAIL);
            end
            default: ;
        endcase
    end

    assign floor_upd = (state_q == S_REPORT) && (status_q == ST_OK) && !down_q;

endmodule

// File: rtl/fwdl_gate_chk.sv
module fwdl_gate_chk #(
    parameter int VER_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por,
    input logic             attr_wr_valid,
    input logic             attr_wr_owner,
    input logic             attr_resp_valid,
    input logic [2:0]       attr_resp_code,
    input logic [1:0]       port_locked,
    input logic [1:0]       port_lock_on_por,
    input logic             dl_req_valid,
    input logic             sig_valid,
    input logic             sig_pass,
    input logic             dl_busy,
    input logic             dl_done,
    input logic [2:0]       dl_status,
    input logic             dl_discard,
    input logic [VER_W-1:0] rollback_floor
);

    p_prim_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_req_valid && !dl_busy && !dl_done && port_locked[0] && !por)
        |=> (dl_done && dl_status == 3'd1 && !dl_busy));

    p_sig_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_busy && sig_valid && !sig_pass && !por)
        |=> (dl_done && dl_discard && dl_status == 3'd3));

    p_por_relock0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (por && port_lock_on_por[0]) |=> port_locked[0]);

    p_por_relock1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (por && port_lock_on_por[1]) |=> port_locked[1]);

    p_deny_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_wr_valid && !attr_wr_owner && !por)
        |=> (attr_resp_valid && attr_resp_code == 3'd4
             && port_locked == $past(port_locked)
             && port_lock_on_por == $past(port_lock_on_por)));

    p_floor_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rollback_floor >= $past(rollback_floor)));

endmodule

bind fwdl_gate fwdl_gate_chk #(.VER_W(VER_W)) u_chk (.*);

// File: tb/test_fwdl_gate.sv
module test_fwdl_gate;

    localparam int CLK_PERIOD = 10;
    localparam int VER_W      = 8;
    localparam int NVEC       = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             por = 1'b0;
    logic             attr_wr_valid = 1'b0;
    logic             attr_wr_sel = 1'b0;
    logic             attr_wr_owner = 1'b0;
    logic             attr_wr_locked = 1'b0;
    logic             attr_wr_lock_on_por = 1'b0;
    logic             attr_resp_valid;
    logic [2:0]       attr_resp_code;
    logic [1:0]       port_locked;
    logic [1:0]       port_lock_on_por;
    logic             dl_req_valid = 1'b0;
    logic [VER_W-1:0] dl_req_version = '0;
    logic             sig_valid = 1'b0;
    logic             sig_pass = 1'b0;
    logic             dl_busy, dl_done, dl_commit, dl_discard;
    logic [2:0]       dl_status;
    logic [VER_W-1:0] rollback_floor;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwdl_gate #(.VER_W(VER_W)) i_fwdl_gate (.*);

    // {floor_after[8], version[8], status[3], sig[1], downgrade_open[1], primary_open[1]}
    localparam logic [21:0] VEC [NVEC] = '{
        {8'd0,  8'd5,  3'd1, 1'b1, 1'b0, 1'b0},  // R2 primary locked
        {8'd5,  8'd5,  3'd0, 1'b1, 1'b0, 1'b1},  // R5 R7 commit raises floor
        {8'd5,  8'd3,  3'd2, 1'b1, 1'b0, 1'b1},  // R3 downgrade port locked
        {8'd5,  8'd3,  3'd0, 1'b1, 1'b1, 1'b1},  // R4 downgrade admitted, floor kept
        {8'd5,  8'd9,  3'd3, 1'b0, 1'b0, 1'b1},  // R6 signature fail
        {8'd9,  8'd9,  3'd0, 1'b1, 1'b0, 1'b1},  // R7 floor to 9
        {8'd9,  8'd2,  3'd1, 1'b1, 1'b1, 1'b0},  // R2 primary checked first
        {8'd9,  8'd9,  3'd3, 1'b0, 1'b1, 1'b1},  // R6 fail, equal version
        {8'd9,  8'd9,  3'd0, 1'b1, 1'b0, 1'b1},  // R7 equal version is no downgrade
        {8'd12, 8'd12, 3'd0, 1'b1, 1'b1, 1'b1}   // R7 raise to 12
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic attr_write(input logic sel, input logic owner, input logic lk,
                              input logic lor, input int exp_code);
        @(negedge clk);
        attr_wr_valid = 1'b1; attr_wr_sel = sel; attr_wr_owner = owner;
        attr_wr_locked = lk; attr_wr_lock_on_por = lor;
        @(posedge clk);
        @(negedge clk);
        attr_wr_valid = 1'b0;
        check(attr_resp_valid && attr_resp_code == 3'(exp_code), "R8/R9 attr resp",
              int'(attr_resp_code), exp_code);
    endtask

    task automatic run_vec(input logic [21:0] v);
        logic       p_open  = v[0];
        logic       d_open  = v[1];
        logic       sg      = v[2];
        logic [2:0] est     = v[5:3];
        logic [7:0] ver     = v[13:6];
        logic [7:0] fl      = v[21:14];
        attr_write(1'b0, 1'b1, !p_open, 1'b1, 0);
        attr_write(1'b1, 1'b1, !d_open, 1'b1, 0);
        @(negedge clk);
        dl_req_valid = 1'b1; dl_req_version = ver;
        @(posedge clk);
        @(negedge clk);
        dl_req_valid = 1'b0;
        if (est == 3'd1 || est == 3'd2) begin
            check(dl_done && dl_status == est && !dl_commit && !dl_busy,
                  "R2/R3 refusal", int'(dl_status), int'(est));
        end else begin
            check(dl_busy && !dl_done, "R5 busy while waiting", int'(dl_busy), 1);
            sig_valid = 1'b1; sig_pass = sg;
            @(posedge clk);
            @(negedge clk);
            sig_valid = 1'b0;
            check(dl_done && dl_status == est && dl_commit == sg && dl_discard == !sg,
                  "R4/R5/R6 outcome", int'(dl_status), int'(est));
        end
        @(posedge clk);
        @(negedge clk);
        check(rollback_floor == fl, "R7 floor", int'(rollback_floor), int'(fl));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(port_locked == 2'b11 && port_lock_on_por == 2'b11, "R1 ports",
              int'(port_locked), 3);
        check(rollback_floor == 0 && !dl_busy && !dl_done && !dl_commit && !attr_resp_valid,
              "R1 idle", int'(rollback_floor), 0);

        for (int k = 0; k < NVEC; k++) begin
            run_vec(VEC[k]);
        end

        // R8 owner write takes effect
        attr_write(1'b0, 1'b1, 1'b0, 1'b0, 0);
        check(port_locked[0] == 1'b0 && port_lock_on_por[0] == 1'b0, "R8 applied",
              int'({port_lock_on_por[0], port_locked[0]}), 0);
        // R9 non-owner write ignored
        attr_write(1'b0, 1'b0, 1'b1, 1'b1, 4);
        check(port_locked[0] == 1'b0 && port_lock_on_por[0] == 1'b0, "R9 ignored",
              int'({port_lock_on_por[0], port_locked[0]}), 0);
        // R10 power cycle: port 0 flag clear stays open, port 1 flag set relocks
        attr_write(1'b1, 1'b1, 1'b0, 1'b1, 0);
        @(negedge clk);
        dl_req_valid = 1'b1; dl_req_version = 8'd20;
        @(posedge clk);
        @(negedge clk);
        dl_req_valid = 1'b0;
        check(dl_busy, "R10 download pending", int'(dl_busy), 1);
        por = 1'b1;
        @(posedge clk);
        @(negedge clk);
        por = 1'b0;
        check(port_locked == 2'b10, "R10 relock by flag", int'(port_locked), 2);
        check(!dl_busy && !dl_done, "R10 download dropped", int'({dl_busy, dl_done}), 0);
        @(posedge clk);
        @(negedge clk);
        check(!dl_done && rollback_floor == 8'd12, "R10 no outcome, floor kept",
              int'(rollback_floor), 12);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule